// File: doc/BRIEF.md
# Cache error status register

This block keeps a 64-bit status word that collects error events from a data cache. Each event arrives as a single-cycle input pulse and sets its own sticky bit. There are four sources: a store ECC error, a single-bit ECC error on a load, the same error seen during a fill, and a tag parity error from each of two probe pipes. The bit stays set until software writes a one to it. Writing a zero to a bit, or writing a bit whose byte strobe is low, changes nothing.

A small down-counter watches the spacing of store ECC errors. When a store error arrives within 6 cycles of the one before it, the second-error bit is set. Tag parity errors cannot be corrected. Each one produces a registered one-cycle machine-check request, whatever the status bit already held.

Top module: `cache_err_status`

## Requirements
- R1: The status word, visible on rd_data_o at all times, uses these bit positions: bit 0 is tag parity on pipe 0 (tperr_i[0]), bit 1 is tag parity on pipe 1 (tperr_i[1]), bit 2 is a store ECC error, bit 3 is a load ECC error, and bit 4 is the second store error. An event in one cycle is visible on rd_data_o from the next rising edge.
- R2: A set bit stays set until a write clears it, whatever the other inputs do.
- R3: A write clears bit i when wr_en_i is high, wr_strb_i[i/8] is high and wr_data_i[i] is 1. A 0 in the data, or a low strobe, leaves the bit unchanged.
- R4: Bit 3 sets on ld_ecc_i or on fill_ecc_i.
- R5: A store ECC error that comes 1 to 6 cycles after the previous store ECC error sets bit 4. One that comes 7 or more cycles later does not.
- R6: If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: mchk_o is high for exactly the one cycle after each cycle in which either bit of tperr_i is high, whether or not the status bits were already set. It is low at every other time.
- R8: Bits 63:5 always read zero, and writes to them have no effect.
- R9: An active-low asynchronous reset clears all status bits, the store-error window and mchk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_ecc_i | input | 1 | Store ECC error pulse |
| ld_ecc_i | input | 1 | Single-bit ECC error on a load |
| fill_ecc_i | input | 1 | Single-bit ECC error during a fill |
| tperr_i | input | 2 | Tag parity error, one bit per probe pipe |
| wr_en_i | input | 1 | Register write enable |
| wr_data_i | input | 64 | Write data; a 1 in a bit clears that status bit |
| wr_strb_i | input | 8 | Byte strobes for the write |
| rd_data_o | output | 64 | Current status word |
| mchk_o | output | 1 | Machine-check request pulse |

## Verification
The assertions take for granted that every input is a known 0 or 1 from the first edge onward, including while reset is held. They also assume the event inputs are sampled only as level pulses, one event per high cycle. The stimulus drives every input to zero before reset is released. It changes inputs only on falling edges, so every pulse lasts exactly one whole cycle. Store-error spacing in the vectors is chosen to land just inside the window (6 cycles) and just outside it (7 cycles).

// File: rtl/cerr_pkg.sv
package cerr_pkg;
  localparam int unsigned BIT_TP0  = 0;
  localparam int unsigned BIT_TP1  = 1;
  localparam int unsigned BIT_ST   = 2;
  localparam int unsigned BIT_LD   = 3;
  localparam int unsigned BIT_SEO  = 4;
  localparam int unsigned NUM_BITS = 5;
  localparam int unsigned NUM_PIPES = 2;

  typedef logic [NUM_BITS-1:0] cerr_vec_t;
endpackage

// File: rtl/cerr_window.sv
module cerr_window #(
  parameter int unsigned WINDOW = 6,
  localparam int unsigned CNT_W = $clog2(WINDOW + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic st_i,
  output logic second_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WINDOW);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (st_i)            cnt_q <= RELOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // nonzero count means the previous store error is at most WINDOW cycles old
  assign second_o = st_i && (cnt_q != '0);
endmodule

// File: rtl/cerr_w1c_bit.sv
module cerr_w1c_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= (q_o & ~clr_i) | set_i;  // set wins
  end
endmodule

// File: rtl/cerr_mchk.sv
module cerr_mchk #(
  parameter int unsigned NUM_PIPES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PIPES-1:0] tperr_i,
  output logic                 mchk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mchk_o <= 1'b0;
    else         mchk_o <= |tperr_i;
  end
endmodule

// File: rtl/cache_err_status.sv
module cache_err_status
  import cerr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WINDOW = 6,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 st_ecc_i,
  input  logic                 ld_ecc_i,
  input  logic                 fill_ecc_i,
  input  logic [NUM_PIPES-1:0] tperr_i,
  input  logic                 wr_en_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [STRB_W-1:0]    wr_strb_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 mchk_o
);
  cerr_vec_t set_v, clr_v, stat_q;
  logic      second;

  cerr_window #(.WINDOW(WINDOW)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .st_i     (st_ecc_i),
    .second_o (second)
  );

  always_comb begin
    set_v          = '0;
    set_v[BIT_TP0] = tperr_i[0];
    set_v[BIT_TP1] = tperr_i[1];
    set_v[BIT_ST]  = st_ecc_i;
    set_v[BIT_LD]  = ld_ecc_i | fill_ecc_i;
    set_v[BIT_SEO] = second;
  end

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    assign clr_v[i] = wr_en_i & wr_strb_i[i/8] & wr_data_i[i];
    cerr_w1c_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[i]),
      .clr_i  (clr_v[i]),
      .q_o    (stat_q[i])
    );
  end

  cerr_mchk #(.NUM_PIPES(NUM_PIPES)) u_mchk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tperr_i (tperr_i),
    .mchk_o  (mchk_o)
  );

  assign rd_data_o = {{(DATA_W-NUM_BITS){1'b0}}, stat_q};

  // reserved write bits intentionally dropped
  logic unused_wr;
  assign unused_wr = ^{wr_data_i[DATA_W-1:NUM_BITS], wr_strb_i};
endmodule

// File: rtl/cerr_status_chk.sv
module cerr_status_chk #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              st_ecc_i,
  input logic              ld_ecc_i,
  input logic              fill_ecc_i,
  input logic [1:0]        tperr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [STRB_W-1:0] wr_strb_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              mchk_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:5] == '0); // R8

  AST_MCHK_ON_TPERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tperr_i) |=> mchk_o); // R7

  AST_MCHK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|tperr_i) |=> !mchk_o); // R7

  AST_TP0_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tperr_i[0] |=> rd_data_o[0]); // R6

  AST_ST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[2] && !(wr_en_i && wr_strb_i[0] && wr_data_i[2])) |=> rd_data_o[2]); // R2

  AST_LD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_strb_i[0] && wr_data_i[3] && !ld_ecc_i && !fill_ecc_i) |=> !rd_data_o[3]); // R3

  AST_LD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ecc_i || fill_ecc_i) |=> rd_data_o[3]); // R4

  AST_SEO_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_ecc_i && $past(st_ecc_i)) |=> rd_data_o[4]); // R5
endmodule

bind cache_err_status cerr_status_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cache_err_status_tb.sv
module cache_err_status_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_ecc_i = 1'b0, ld_ecc_i = 1'b0, fill_ecc_i = 1'b0;
  logic [1:0]  tperr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic [7:0]  wr_strb_i = '0;
  logic [63:0] rd_data_o;
  logic        mchk_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  cache_err_status u_dut (.*);

  // {st, ld, fill, tp0, tp1, wr, strb0, wdata[4:0], exp_status[4:0], exp_mchk}
  localparam int NV = 40;
  localparam logic [17:0] VEC [NV] = '{
    18'b0_0_0_0_0_0_0_00000_00000_0,  // idle
    18'b0_0_0_1_0_0_0_00000_00001_1,  // tp0
    18'b0_0_0_0_1_0_0_00000_00011_1,  // tp1
    18'b0_0_0_0_0_0_0_00000_00011_0,  // hold
    18'b0_0_0_0_0_1_1_00001_00010_0,  // clear bit0
    18'b0_0_0_0_0_1_0_00010_00010_0,  // strobe low, ignored
    18'b0_0_0_0_0_1_1_00010_00000_0,  // clear bit1
    18'b0_1_0_0_0_0_0_00000_01000_0,  // load ecc
    18'b0_0_1_0_0_0_0_00000_01000_0,  // fill ecc
    18'b0_0_0_0_0_1_1_01000_00000_0,
    18'b0_0_1_0_0_0_0_00000_01000_0,  // fill alone
    18'b0_0_0_0_0_1_1_11111_00000_0,
    18'b1_0_0_0_0_0_0_00000_00100_0,  // store, window opens
    18'b0_0_0_0_0_0_0_00000_00100_0,
    18'b0_0_0_0_0_0_0_00000_00100_0,
    18'b0_0_0_0_0_0_0_00000_00100_0,
    18'b0_0_0_0_0_0_0_00000_00100_0,
    18'b0_0_0_0_0_0_0_00000_00100_0,
    18'b1_0_0_0_0_0_0_00000_10100_0,  // 6 cycles later: second
    18'b0_0_0_0_0_1_1_10100_00000_0,
    18'b0_0_0_0_0_0_0_00000_00000_0,
    18'b0_0_0_0_0_0_0_00000_00000_0,
    18'b0_0_0_0_0_0_0_00000_00000_0,
    18'b0_0_0_0_0_0_0_00000_00000_0,
    18'b0_0_0_0_0_0_0_00000_00000_0,
    18'b1_0_0_0_0_0_0_00000_00100_0,  // window closed
    18'b0_0_0_0_0_0_0_00000_00100_0,
    18'b0_0_0_0_0_0_0_00000_00100_0,
    18'b0_0_0_0_0_0_0_00000_00100_0,
    18'b0_0_0_0_0_0_0_00000_00100_0,
    18'b0_0_0_0_0_0_0_00000_00100_0,
    18'b0_0_0_0_0_0_0_00000_00100_0,
    18'b1_0_0_0_0_0_0_00000_00100_0,  // 7 cycles later: no second
    18'b1_0_0_0_0_0_0_00000_10100_0,  // back to back
    18'b0_0_0_1_0_1_1_11111_00001_1,  // event beats clear
    18'b1_0_0_0_0_1_1_00001_10100_0,
    18'b0_0_0_0_0_1_1_11111_00000_0,
    18'b0_0_0_1_1_0_0_00000_00011_1,  // both pipes
    18'b0_0_0_1_0_0_0_00000_00011_1,  // already set, still pulses
    18'b0_0_0_0_0_1_1_11111_00000_0
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    st_ecc_i = 0; ld_ecc_i = 0; fill_ecc_i = 0; tperr_i = '0;
    wr_en_i = 0; wr_data_i = '0; wr_strb_i = '0;
  endtask

  task automatic cycle_check(input string req, input logic [63:0] exp_stat, input logic exp_m);
    @(posedge clk_i); #5;
    check(req, rd_data_o, exp_stat);
    check({req, " mchk"}, {63'b0, mchk_o}, {63'b0, exp_m});
    @(negedge clk_i);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    #35;
    check("R9 reset status", rd_data_o, 64'h0);
    check("R9 reset mchk", {63'b0, mchk_o}, 64'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v = VEC[i];
      st_ecc_i = v[17]; ld_ecc_i = v[16]; fill_ecc_i = v[15];
      tperr_i = {v[13], v[14]}; wr_en_i = v[12]; wr_strb_i = {7'b0, v[11]};
      wr_data_i = {59'b0, v[10:6]};
      cycle_check($sformatf("R1/R2/R3/R4/R5/R6/R7 vec%0d", i), {59'b0, v[5:1]}, v[0]);
    end

    // R8: reserved bits ignore writes and read zero
    wr_en_i = 1; wr_strb_i = 8'hFF; wr_data_i = '1;
    cycle_check("R8 all-ones write", 64'h0, 1'b0);
    tperr_i = 2'b01;
    cycle_check("R8 setup", 64'h1, 1'b1);
    wr_en_i = 1; wr_strb_i = 8'hFF; wr_data_i = 64'hFFFF_FFFF_FFFF_FFE0;
    cycle_check("R8 reserved write", 64'h1, 1'b0);

    // R9: mid-run reset clears status and window
    st_ecc_i = 1; tperr_i = 2'b10;
    cycle_check("R9 setup", 64'h7, 1'b1);
    #2 rst_ni = 1'b0; #3;
    check("R9 async status", rd_data_o, 64'h0);
    check("R9 async mchk", {63'b0, mchk_o}, 64'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    st_ecc_i = 1;
    cycle_check("R9 window cleared", 64'h4, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule